// File: doc/BRIEF.md
# Four-Channel PWM Generator with Reload Interrupts

This block drives four PWM outputs. Each channel has its own timer and its own period register. Software writes the wanted duty value into a duty register. A shadow copy of that value is the one actually compared with the timer. The duty register is copied into the shadow only at the moment the channel's timer stands at zero. As a result, a new duty value never cuts a PWM cycle short. It also means the duty register becomes free for the next value at a point in time that software can see.

That same copy event is what raises the channel's interrupt request, if the channel's request enable is set. All four requests feed one shared interrupt line, which is gated by a module enable. The line does not say which channel raised it, so software reads the per-channel request flags to find the source. A channel can count edge-aligned (up, then wrap) or center-aligned (up, then down). It can run continuously or in single-shot form. Its pin can be switched off while the channel keeps counting and keeps raising requests. A `tick` input acts as the clock enable for all four timers. Software reaches the block through a simple register bus: a write strobe, an address and write data, with read data returned combinationally.

Top module: `pwm_quad`

## Requirements
- R1: After reset, every register reads 0000h, all four pins are low and `irq` is low. Each channel is then edge-aligned, continuous, pin-disabled and has its request disabled.
- R2: In edge-aligned mode the timer steps on each tick through 0, 1, ..., P and then returns to 0, where P is the period. Over any P+1 consecutive ticks the pin is high for P-D+1 of them when D <= P, and for none of them when D > P (D is the shadow value).
- R3: In center-aligned mode the timer steps through 0, 1, ..., P, P-1, ..., 1 and repeats. Over any 2P consecutive ticks the pin is high for 2(P-D)+1 of them when 0 < D <= P.
- R4: A duty write takes effect only at the next tick on which the timer is at zero. Until then the pin keeps following the previous shadow value.
- R5: When a channel's pin enable is 0, its pin stays low. The channel still counts and still raises its request.
- R6: A channel's request flag (FLAGS bit c) is set on the clock edge of a tick that finds the timer at zero, if that channel's request enable is 1. No flag is set on a channel whose enable is 0.
- R7: The module flag (FLAGS bit 9) is set one clock after any channel has both its request flag and its request enable at 1, provided the module enable (FLAGS bit 8) is 1. The `irq` pin equals the module flag.
- R8: Request flags and the module flag stay set until software writes 0 to them. Writing 1 to a flag bit leaves it unchanged.
- R9: If a flag's set condition and a software clear fall in the same clock, the flag ends up set.
- R10: In single-shot mode the timer stops at zero after its terminal step (edge: reaching P; center: stepping down to 0). A stopped timer makes no further shadow copies. Writing 1 to START bit c re-arms channel c.
- R11: A shadow value of 0 makes an enabled pin high on every tick.
- R12: While `tick` is low, no timer moves and no shadow copy or request occurs.
- R13: The register map is as follows. CTRL at 0 has center mode in bits 3:0, single-shot in bits 7:4, pin enable in bits 11:8 and request enable in bits 15:12, with bit c of each field belonging to channel c. FLAGS is at 1. START is at 2 and reads 0. PERIOD c is at 4+c and DUTY c is at 8+c. All of these read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Clock enable for all channel timers |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data for `bus_addr` |
| pwm_out | output | 4 | PWM pins, bit c is channel c |
| irq | output | 1 | Shared module interrupt |

## Verification
The hardest case to reach from the ports is a software clear that lands in the same clock as a shadow copy. In normal operation the copy happens only once per timer cycle, at a phase that software cannot see. The stimulus avoids that problem by setting the period to 0. The timer then sits at zero and every tick copies the shadow. A bus write that clears the flags, issued together with a tick, therefore always collides with the set condition. Because the module flag's set term lags the channel flag by one clock, the next plain clear collides with the module flag as well.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
  localparam int NCH    = 4;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 4;

  // register addresses
  localparam int A_CTRL  = 0;
  localparam int A_FLAG  = 1;
  localparam int A_START = 2;
  localparam int A_PER0  = 4;
  localparam int A_DUTY0 = 8;

  // CTRL field bases (bit c of each field belongs to channel c)
  localparam int C_CENTER = 0;
  localparam int C_SINGLE = NCH;
  localparam int C_OE     = 2 * NCH;
  localparam int C_PIE    = 3 * NCH;

  // FLAGS bits above the per-channel request flags
  localparam int F_MEN = 8;
  localparam int F_MIR = 9;

  typedef struct packed {
    logic center;
    logic single;
    logic oe;
    logic pie;
  } chan_cfg_t;
endpackage

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
  import pwm_quad_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_we,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [REG_W-1:0]              bus_wdata,
  output logic [REG_W-1:0]              bus_rdata,
  input  logic [NCH-1:0]                pir,
  input  logic                          mod_flag,
  output chan_cfg_t [NCH-1:0]           cfg,
  output logic                          mod_en,
  output logic [NCH-1:0][CNT_W-1:0]     period,
  output logic [NCH-1:0][CNT_W-1:0]     duty,
  output logic [NCH-1:0]                start,
  output logic [NCH-1:0]                clr_pir,
  output logic                          clr_mod
);
  logic [REG_W-1:0] ctrl_q;
  logic             men_q;

  wire wr_ctrl = bus_we && (bus_addr == ADDR_W'(A_CTRL));
  wire wr_flag = bus_we && (bus_addr == ADDR_W'(A_FLAG));
  wire wr_strt = bus_we && (bus_addr == ADDR_W'(A_START));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      men_q  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata;
      if (wr_flag) men_q  <= bus_wdata[F_MEN];
    end
  end

  assign mod_en  = men_q;
  assign clr_mod = wr_flag && !bus_wdata[F_MIR];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        period[c] <= '0;
        duty[c]   <= '0;
      end else begin
        if (bus_we && bus_addr == ADDR_W'(A_PER0 + c))  period[c] <= bus_wdata[CNT_W-1:0];
        if (bus_we && bus_addr == ADDR_W'(A_DUTY0 + c)) duty[c]   <= bus_wdata[CNT_W-1:0];
      end
    end
    assign cfg[c].center = ctrl_q[C_CENTER + c];
    assign cfg[c].single = ctrl_q[C_SINGLE + c];
    assign cfg[c].oe     = ctrl_q[C_OE + c];
    assign cfg[c].pie    = ctrl_q[C_PIE + c];
    assign start[c]      = wr_strt && bus_wdata[c];
    assign clr_pir[c]    = wr_flag && !bus_wdata[c];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(A_CTRL)) bus_rdata = ctrl_q;
    if (bus_addr == ADDR_W'(A_FLAG)) begin
      bus_rdata[NCH-1:0] = pir;
      bus_rdata[F_MEN]   = men_q;
      bus_rdata[F_MIR]   = mod_flag;
    end
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr == ADDR_W'(A_PER0 + c))  bus_rdata = REG_W'(period[c]);
      if (bus_addr == ADDR_W'(A_DUTY0 + c)) bus_rdata = REG_W'(duty[c]);
    end
  end
endmodule

// File: rtl/pwm_quad_chan.sv
module pwm_quad_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             center,
  input  logic             single,
  input  logic             oe,
  input  logic             start,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty,
  output logic             shadow_ld,
  output logic             pwm
);
  logic [CNT_W-1:0] cnt_q, cnt_n, shadow_q;
  logic             down_q, down_n, run_q, term;

  wire active = run_q | ~single;
  assign shadow_ld = tick && active && (cnt_q == '0);

  // next timer state and terminal-step detection
  always_comb begin
    cnt_n  = cnt_q + CNT_W'(1);
    down_n = 1'b0;
    term   = 1'b0;
    if (!center) begin
      if (cnt_q >= period) begin
        cnt_n = '0;
        term  = 1'b1;
      end
    end else if (down_q || cnt_q >= period) begin
      if (cnt_q <= CNT_W'(1)) begin
        cnt_n = '0;
        term  = 1'b1;
      end else begin
        cnt_n  = cnt_q - CNT_W'(1);
        down_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      down_q   <= 1'b0;
      run_q    <= 1'b1;
      shadow_q <= '0;
    end else begin
      if (start)                                 run_q <= 1'b1;
      else if (tick && active && single && term) run_q <= 1'b0;
      if (tick && active) begin
        cnt_q  <= cnt_n;
        down_q <= down_n;
      end
      if (shadow_ld) shadow_q <= duty;
    end
  end

  assign pwm = oe && (cnt_q >= shadow_q);

  p_freeze_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));

  p_hold_shadow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !shadow_ld |=> $stable(shadow_q));

  p_stopped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (single && !run_q && !start) |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_quad_flags.sv
module pwm_quad_flags
  import pwm_quad_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ld,
  input  logic [NCH-1:0] pie,
  input  logic           mod_en,
  input  logic [NCH-1:0] clr_pir,
  input  logic           clr_mod,
  output logic [NCH-1:0] pir,
  output logic           mod_flag
);
  wire mod_set = mod_en && |(pir & pie);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pir      <= '0;
      mod_flag <= 1'b0;
    end else begin
      pir      <= (pir & ~clr_pir) | (ld & pie);
      mod_flag <= (mod_flag & ~clr_mod) | mod_set;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    p_pir_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ld[c] && pie[c]) |=> pir[c]);
    p_pir_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pir[c] && !clr_pir[c]) |=> pir[c]);
  end

  p_mod_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && |(pir & pie)) |=> mod_flag);

  p_mod_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_flag && !clr_mod) |=> mod_flag);
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwm_quad_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic [NCH-1:0]    pwm_out,
  output logic              irq
);
  chan_cfg_t [NCH-1:0]       cfg;
  logic [NCH-1:0][CNT_W-1:0] period, duty;
  logic [NCH-1:0]            start, clr_pir, ld, pie, pir;
  logic                      mod_en, clr_mod, mod_flag;

  pwm_quad_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pir(pir), .mod_flag(mod_flag),
    .cfg(cfg), .mod_en(mod_en), .period(period), .duty(duty), .start(start),
    .clr_pir(clr_pir), .clr_mod(clr_mod)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign pie[c] = cfg[c].pie;
    pwm_quad_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .tick(tick), .center(cfg[c].center),
      .single(cfg[c].single), .oe(cfg[c].oe), .start(start[c]),
      .period(period[c]), .duty(duty[c]), .shadow_ld(ld[c]), .pwm(pwm_out[c])
    );
  end

  pwm_quad_flags u_flags (
    .clk(clk), .rst_n(rst_n), .ld(ld), .pie(pie), .mod_en(mod_en),
    .clr_pir(clr_pir), .clr_mod(clr_mod), .pir(pir), .mod_flag(mod_flag)
  );

  assign irq = mod_flag;
endmodule

// File: tb/tb_pwm_quad.sv
module tb_pwm_quad;
  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  pwm_out;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  pwm_quad dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic cyc(input bit t, input bit w, input logic [3:0] a, input logic [15:0] d);
    tick = t; bus_we = w; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    tick = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d); cyc(0, 1, a, d); endtask
  task automatic tk(); cyc(1, 0, 4'd0, 16'd0); endtask
  task automatic idle(); cyc(0, 0, 4'd0, 16'd0); endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic count_hi(input int ch, input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      tk();
      if (pwm_out[ch]) h++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0; bus_we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    do_reset();
    for (int a = 0; a < 12; a++) begin
      rd(4'(a), v);
      chk($sformatf("R1 reg %0d after reset", a), v, 0);
    end
    chk("R1 pins after reset", pwm_out, 0);
    chk("R1 irq after reset", irq, 0);
  endtask

  task automatic t_edge();
    int h;
    do_reset();
    wr(4, 4); wr(8, 2); wr(0, 16'h0100);
    tk();
    chk("R2 first tick timer=1 below duty", pwm_out[0], 0);
    count_hi(0, 10, h);
    chk("R2 edge P=4 D=2 high ticks", h, 6);
    wr(8, 5);
    count_hi(0, 5, h);
    count_hi(0, 10, h);
    chk("R2 edge D>P never high", h, 0);
  endtask

  task automatic t_center();
    int h;
    do_reset();
    wr(5, 4); wr(9, 2); wr(0, 16'h0202);
    tk();
    count_hi(1, 16, h);
    chk("R3 center P=4 D=2 high ticks", h, 10);
    wr(9, 0);
    count_hi(1, 8, h);
    count_hi(1, 8, h);
    chk("R11 shadow 0 always high", h, 8);
  endtask

  task automatic t_shadow();
    int h;
    logic [15:0] v;
    do_reset();
    wr(4, 4); wr(8, 1); wr(0, 16'h0100);
    tk();
    chk("R4 loaded D=1 at timer 1", pwm_out[0], 1);
    wr(8, 4);
    tk();
    chk("R4 old shadow still used mid-period", pwm_out[0], 1);
    tk(); tk(); tk(); tk();
    count_hi(0, 5, h);
    chk("R4 new duty after zero", h, 1);
    rd(8, v);
    chk("R13 duty readback", v, 4);
  endtask

  task automatic t_irq();
    int h;
    logic [15:0] v;
    do_reset();
    wr(6, 2); wr(10, 0); wr(0, 16'h4000); wr(1, 16'h0100);
    repeat (5) idle();
    rd(1, v);
    chk("R12 no request without tick", v, 16'h0100);
    tk();
    rd(1, v);
    chk("R6 pir2 set, pir3 clear", v, 16'h0104);
    chk("R7 irq not yet", irq, 0);
    idle();
    chk("R7 irq one clock later", irq, 1);
    count_hi(2, 6, h);
    chk("R5 disabled pin stays low", h, 0);
    rd(1, v);
    chk("R5 request still raised", v, 16'h0304);
    wr(1, 16'h03FF);
    rd(1, v);
    chk("R8 writing ones keeps flags", v, 16'h0304);
    wr(1, 16'h0300);
    rd(1, v);
    chk("R8 write zero clears pir2", v, 16'h0300);
    chk("R8 irq stays set", irq, 1);
    wr(1, 16'h0100);
    rd(1, v);
    chk("R8 module flag cleared", v, 16'h0100);
    chk("R7 irq follows module flag", irq, 0);
  endtask

  task automatic t_setwins();
    logic [15:0] v;
    do_reset();
    wr(4, 0); wr(0, 16'h1000); wr(1, 16'h0100);
    tk();
    idle();
    rd(1, v);
    chk("R9 setup flags", v, 16'h0301);
    cyc(1, 1, 4'd1, 16'h0100);
    rd(1, v);
    chk("R9 set beats clear", v, 16'h0301);
    wr(1, 16'h0100);
    rd(1, v);
    chk("R9 module set beats clear", v, 16'h0300);
    wr(1, 16'h0100);
    rd(1, v);
    chk("R9 module clears once source gone", v, 16'h0100);
  endtask

  task automatic t_single();
    int h;
    logic [15:0] v;
    do_reset();
    wr(4, 3); wr(8, 2); wr(0, 16'h1110);
    tk();
    rd(1, v);
    chk("R10 first load raises pir0", v, 16'h0001);
    wr(1, 16'h0000);
    count_hi(0, 12, h);
    chk("R10 one shot high ticks", h, 2);
    rd(1, v);
    chk("R10 stopped timer no reload", v, 16'h0000);
    wr(2, 16'h0001);
    tk();
    rd(1, v);
    chk("R10 re-arm reloads", v, 16'h0001);
  endtask

  task automatic t_regs();
    logic [15:0] v;
    do_reset();
    wr(0, 16'hA5C3); rd(0, v); chk("R13 ctrl readback", v, 16'hA5C3);
    wr(6, 16'h1234); rd(6, v); chk("R13 period2 readback", v, 16'h1234);
    wr(11, 16'hBEEF); rd(11, v); chk("R13 duty3 readback", v, 16'hBEEF);
    wr(2, 16'h000F); rd(2, v); chk("R13 start reads zero", v, 0);
  endtask

  initial begin
    t_reset();
    t_edge();
    t_center();
    t_shadow();
    t_irq();
    t_setwins();
    t_single();
    t_regs();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1-R13 run hung actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule